// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This unit adds or subtracts two packed operands lane by lane. At run time, one adder datapath splits into independent lanes. The lane widths are 8, 16, 32 or the full 64 bits. Carries never cross a lane boundary. Each lane then takes one of three treatments:

- keep the low bits (wrap),
- clamp to the unsigned range,
- clamp to the signed range.

A pipeline stage issues an operation by raising `in_valid` with both operands and the controls. One cycle later the registered result appears with `out_valid`. A per-byte flag vector marks every byte that belongs to a lane that was clamped. When no operation is issued, the output register keeps its last contents.

Top module: `simd_sat_adder`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. With `in_valid` low, `out_valid` drops and `result` and `sat_flags` keep their previous values.
- R2: A synchronous active-high `rst` clears `out_valid`, `result` and `sat_flags` to zero at the next clock edge.
- R3: The `lane_sel` encoding is 0 = eight 8-bit lanes, 1 = four 16-bit lanes, 2 = two 32-bit lanes and 3 = one 64-bit lane. Lane k occupies bits [k*w +: w], and no carry or borrow passes from one lane into the next.
- R4: With `mode` = 0 (wrap), each lane holds the low w bits of the sum or difference, and `sat_flags` is zero.
- R5: With `mode` = 1 (unsigned saturate) and `sub` = 0, a lane whose sum exceeds 2^w-1 becomes all ones. For byte lanes that value is 255.
- R6: With `mode` = 1 and `sub` = 1, a lane where b is greater than a becomes zero.
- R7: With `mode` = 2 (signed saturate), a lane that overflows positively becomes 2^(w-1)-1, and a lane that overflows negatively becomes -2^(w-1).
- R8: `sub` = 1 computes a minus b in every lane. `sub` = 0 computes a plus b.
- R9: `sat_flags` bit i refers to byte i of the result. It is set when the lane containing that byte was clamped, so a clamped lane sets all of its bytes' flags. It is clear otherwise.
- R10: `mode` = 3 behaves exactly as wrap mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opa | input | 64 | Packed operand a |
| opb | input | 64 | Packed operand b |
| lane_sel | input | 2 | Lane width select (R3 encoding) |
| mode | input | 2 | 0 wrap, 1 unsigned saturate, 2 signed saturate, 3 wrap |
| sub | input | 1 | 1 = a minus b, 0 = a plus b |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered packed result |
| sat_flags | output | 8 | Per-byte clamp flags, bit i for byte i |

## Verification
The bench builds the unit with the default 64-bit width. With that width all four lane sizes exist, including the single full-width lane, where the carry out of the top byte decides the clamp.

Directed cases target the following:
- lane-boundary carries, such as 0xFF plus 1 at every lane size;
- clamps at both ends of the unsigned and signed ranges;
- subtraction underflow.

Seeded random operands run across every lane and mode combination. Operands with heavy top bits are included so that clamps occur often.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_B64 = 2'd3
  } lane_e;

  typedef enum logic [1:0] {
    ARITH_WRAP = 2'd0,
    ARITH_USAT = 2'd1,
    ARITH_SSAT = 2'd2,
    ARITH_ALT  = 2'd3
  } arith_e;

  // Mask of byte-index bits that lie inside one lane.
  function automatic int lane_mask(input logic [1:0] sel);
    return (1 << sel) - 1;
  endfunction

  // True when byte idx starts a new lane.
  function automatic logic lane_first(input int idx, input logic [1:0] sel);
    return (idx & lane_mask(sel)) == 0;
  endfunction

  // Index of the most significant byte of the lane holding byte idx.
  function automatic int lane_top(input int idx, input logic [1:0] sel);
    return idx | lane_mask(sel);
  endfunction

  // Unsigned overflow (add) or underflow (sub) from the lane carry out.
  function automatic logic unsigned_clip(input logic sub, input logic carry);
    return sub ? ~carry : carry;
  endfunction

  // Signed overflow: operands agree in sign, result disagrees.
  function automatic logic signed_clip(input logic a_msb, input logic b_msb,
                                       input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  // Byte written into a clamped lane.
  function automatic logic [7:0] fill_byte(input arith_e md, input logic high,
                                           input logic neg, input logic is_top);
    logic [7:0] v;
    case (md)
      ARITH_USAT: v = high ? 8'hFF : 8'h00;
      ARITH_SSAT: begin
        if (neg) v = is_top ? 8'h80 : 8'h00;
        else     v = is_top ? 8'h7F : 8'hFF;
      end
      default:    v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/simd_byte_adder.sv
module simd_byte_adder
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        lane_sel,
  input  logic              sub,
  output logic [DATA_W-1:0] bx_o,
  output logic [DATA_W-1:0] sum_o,
  output logic [NBYTES-1:0] cout_o
);

  assign bx_o = b ^ {DATA_W{sub}};

  // Ripple through byte slices; the carry is reloaded at each lane start.
  always_comb begin
    logic       c;
    logic [8:0] part;
    c = sub;
    sum_o  = '0;
    cout_o = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (lane_first(i, lane_sel)) c = sub;
      part = {1'b0, a[i*8 +: 8]} + {1'b0, bx_o[i*8 +: 8]} + {8'd0, c};
      sum_o[i*8 +: 8] = part[7:0];
      cout_o[i]       = part[8];
      c               = part[8];
    end
  end

endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] bx,
  input  logic [DATA_W-1:0] sum,
  input  logic [NBYTES-1:0] cout,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        mode,
  input  logic              sub,
  output logic [DATA_W-1:0] res_o,
  output logic [NBYTES-1:0] hit_o
);

  arith_e md;
  assign md = arith_e'(mode);

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    int   top;
    logic a7, b7, s7, clip;

    always_comb begin
      top = lane_top(i, lane_sel);
      a7  = a[top*8 + 7];
      b7  = bx[top*8 + 7];
      s7  = sum[top*8 + 7];
      case (md)
        ARITH_USAT: clip = unsigned_clip(sub, cout[top]);
        ARITH_SSAT: clip = signed_clip(a7, b7, s7);
        default:    clip = 1'b0;
      endcase
      hit_o[i]         = clip;
      res_o[i*8 +: 8]  = clip ? fill_byte(md, ~sub, a7, top == i)
                              : sum[i*8 +: 8];
    end
  end

endmodule

// File: rtl/simd_out_reg.sv
module simd_out_reg #(
  parameter int DATA_W = 64,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d_res,
  input  logic [NBYTES-1:0] d_flag,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_res,
  output logic [NBYTES-1:0] q_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_res   <= '0;
      q_flag  <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_res  <= d_res;
        q_flag <= d_flag;
      end
    end
  end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        mode,
  input  logic              sub,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [NBYTES-1:0] sat_flags
);

  logic [DATA_W-1:0] bx_w;
  logic [DATA_W-1:0] raw_sum;
  logic [NBYTES-1:0] byte_cout;
  logic [DATA_W-1:0] clamped;
  logic [NBYTES-1:0] sat_evt;   // per-byte clamp event, visible to the checker

  simd_byte_adder #(.DATA_W(DATA_W)) u_add (
    .a        (opa),
    .b        (opb),
    .lane_sel (lane_sel),
    .sub      (sub),
    .bx_o     (bx_w),
    .sum_o    (raw_sum),
    .cout_o   (byte_cout)
  );

  simd_lane_clamp #(.DATA_W(DATA_W)) u_clamp (
    .a        (opa),
    .bx       (bx_w),
    .sum      (raw_sum),
    .cout     (byte_cout),
    .lane_sel (lane_sel),
    .mode     (mode),
    .sub      (sub),
    .res_o    (clamped),
    .hit_o    (sat_evt)
  );

  simd_out_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d_res   (clamped),
    .d_flag  (sat_evt),
    .q_valid (out_valid),
    .q_res   (result),
    .q_flag  (sat_flags)
  );

endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int DATA_W = 64,
  localparam int NBYTES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        lane_sel,
  input logic [1:0]        mode,
  input logic              sub,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [NBYTES-1:0] sat_flags,
  input logic [NBYTES-1:0] sat_evt
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(sat_flags)));

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && sat_flags == '0));

  // R4 R10
  wrap_no_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 2'd0 || mode == 2'd3)) |=> sat_flags == '0);

  // R9
  flag_capture_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> sat_flags == $past(sat_evt));

  // R9
  flag_wide_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sel == 2'd3) |=> (sat_flags == '0 || sat_flags == '1));

  for (genvar i = 0; i < NBYTES; i++) begin : g_chk
    // R5
    usat_top_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 2'd1 && !sub) |=>
        (!sat_flags[i] || result[i*8 +: 8] == 8'hFF));
    // R6
    usat_floor_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 2'd1 && sub) |=>
        (!sat_flags[i] || result[i*8 +: 8] == 8'h00));
    // R7
    ssat_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 2'd2) |=>
        (!sat_flags[i] || result[i*8 +: 8] == 8'h7F || result[i*8 +: 8] == 8'hFF ||
         result[i*8 +: 8] == 8'h80 || result[i*8 +: 8] == 8'h00));
  end

endmodule

bind simd_sat_adder simd_sat_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .lane_sel  (lane_sel),
  .mode      (mode),
  .sub       (sub),
  .out_valid (out_valid),
  .result    (result),
  .sat_flags (sat_flags),
  .sat_evt   (sat_evt)
);

// File: tb/simd_sat_adder_tb.sv
`timescale 1ns/1ps
module simd_sat_adder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic [1:0]  lane_sel = '0, mode = '0;
  logic        sub = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  sat_flags;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  simd_sat_adder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
    .lane_sel(lane_sel), .mode(mode), .sub(sub),
    .out_valid(out_valid), .result(result), .sat_flags(sat_flags)
  );

  // Independent model: per-lane arithmetic in wide integers.
  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] ls, input logic [1:0] md,
                                input logic s, output logic [63:0] r,
                                output logic [7:0] f);
    int w, n;
    w = 8 << ls;
    n = 64 / w;
    r = '0;
    f = '0;
    for (int k = 0; k < n; k++) begin
      logic [65:0] msk, ua, ub, half, lane;
      logic signed [65:0] sa, sb, ss, smax, smin;
      logic clip;
      msk  = (66'd1 << w) - 66'd1;
      half = 66'd1 << (w - 1);
      ua   = ({2'b00, a} >> (k * w)) & msk;
      ub   = ({2'b00, b} >> (k * w)) & msk;
      clip = 1'b0;
      if (md == 2'd1) begin
        if (!s) begin
          lane = ua + ub;
          if (lane > msk) begin lane = msk; clip = 1'b1; end
        end else if (ua < ub) begin
          lane = '0; clip = 1'b1;
        end else lane = ua - ub;
      end else if (md == 2'd2) begin
        sa   = $signed(ua ^ half) - $signed(half);
        sb   = $signed(ub ^ half) - $signed(half);
        smax = $signed(half) - 66'sd1;
        smin = -$signed(half);
        ss   = s ? sa - sb : sa + sb;
        if (ss > smax) begin ss = smax; clip = 1'b1; end
        if (ss < smin) begin ss = smin; clip = 1'b1; end
        lane = 66'(ss) & msk;
      end else begin
        lane = (s ? ua - ub : ua + ub) & msk;
      end
      r = r | (64'(lane) << (k * w));
      if (clip) f = f | (((8'd1 << (w / 8)) - 8'd1) << (k * (w / 8)));
    end
  endfunction

  task automatic check(input string req, input logic [63:0] act_r, input logic [7:0] act_f,
                       input logic act_v, input logic [63:0] exp_r,
                       input logic [7:0] exp_f, input logic exp_v);
    n_run++;
    if (act_r !== exp_r || act_f !== exp_f || act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: result=%h flags=%h valid=%b expected result=%h flags=%h valid=%b",
               req, act_r, act_f, act_v, exp_r, exp_f, exp_v);
    end
  endtask

  task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] ls, input logic [1:0] md, input logic s);
    logic [63:0] er;
    logic [7:0]  ef;
    model(a, b, ls, md, s, er, ef);
    @(negedge clk);
    opa = a; opb = b; lane_sel = ls; mode = md; sub = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, result, sat_flags, out_valid, er, ef, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] held_r;
    logic [7:0]  held_f;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 reset", result, sat_flags, out_valid, '0, '0, 1'b0);
    rst = 1'b0;

    // R3 carry isolation at each lane width, wrap mode
    for (int ls = 0; ls < 4; ls++)
      run_op("R3 lane isolation", 64'h00FF_FFFF_00FF_00FF, 64'h0001_0001_0001_0001,
             2'(ls), 2'd0, 1'b0);
    // R4 literal check: byte lanes wrap 0xFF+0x01 to 0x00
    run_op("R4 wrap bytes", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 1'b0);
    check("R4 wrap literal", result, sat_flags, out_valid, 64'h0, 8'h00, 1'b1);
    // R5 literal: 0xF0 + 0x20 clamps to 255 in byte lane 0 only
    run_op("R5 usat byte", 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0020, 2'd0, 2'd1, 1'b0);
    check("R5 usat literal", result, sat_flags, out_valid, 64'h0000_0000_0000_00FF, 8'h01, 1'b1);
    run_op("R5 usat 16", 64'hFFF0_0001_8000_1234, 64'h0020_0002_8000_0001, 2'd1, 2'd1, 1'b0);
    run_op("R5 usat 64", 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 2'd3, 2'd1, 1'b0);
    // R6 underflow to zero
    run_op("R6 usat sub", 64'h0010_2000_0000_0005, 64'h0020_1000_0000_0006, 2'd1, 2'd1, 1'b1);
    run_op("R6 usat sub 32", 64'h1, 64'h2, 2'd2, 2'd1, 1'b1);
    // R7 signed positive and negative overflow
    run_op("R7 ssat 16", 64'h7FFF_8000_7000_9000, 64'h0001_FFFF_1000_9000, 2'd1, 2'd2, 1'b0);
    run_op("R7 ssat 32 sub", 64'h7FFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0001, 2'd2, 2'd2, 1'b1);
    run_op("R7 ssat 64", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd3, 2'd2, 1'b0);
    // R8 subtraction in wrap mode
    run_op("R8 wrap sub", 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 2'd2, 2'd0, 1'b1);
    // R10 mode 3 matches wrap
    run_op("R10 alt mode", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd1, 2'd3, 1'b0);

    // R1: idle cycle holds result and drops valid
    held_r = result; held_f = sat_flags;
    @(negedge clk);
    opa = 64'h1234; opb = 64'h5678; mode = 2'd1;
    @(negedge clk);
    check("R1 idle hold", result, sat_flags, out_valid, held_r, held_f, 1'b0);

    // R9 and all: random sweep with biased operands
    for (int t = 0; t < 400; t++) begin
      logic [63:0] a, b;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      if (t % 3 == 0) a = a | 64'h8080_8080_8080_8080;
      if (t % 5 == 0) b = b | 64'hF0F0_F0F0_F0F0_F0F0;
      run_op("R9 random", a, b, 2'($urandom_range(3)), 2'($urandom_range(3)),
             1'($urandom_range(1)));
    end

    // R2: reset during operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R2 mid reset", result, sat_flags, out_valid, '0, '0, 1'b0);
    rst = 1'b0;
    finish_run();
  end

endmodule